// File: doc/BRIEF.md
# Unpacked-BCD Adjust Unit with Word-Wide Correction

This unit performs the fix-up step that follows an addition or a subtraction of unpacked BCD digits held in a 16-bit accumulator. The low byte carries the digit and the high byte is the next digit up. A one-bit select chooses the fix-up. Select 0 is the fix-up after addition and select 1 is the fix-up after subtraction. Along with the accumulator value, the unit takes the half-carry flag left by the preceding arithmetic. It returns the adjusted accumulator, the new half-carry flag and the new carry flag.

Out-of-range inputs follow the behaviour that silicon shows, which differs from the textbook description. The correction of 6 is applied to the whole 16-bit word, not only to the low byte. A carry or borrow out of the low byte therefore reaches the high byte, and the explicit ±1 step of the high byte is applied on top of it. Results wrap within 16 bits. The outputs are registered, so each result appears one clock after its inputs.

Top module: `ascii_adj_unit`

## Requirements
- R1: A correction is taken when the half-carry input is 1 or when bits 3:0 of the accumulator exceed 9. When it is taken, both output flags are 1. Otherwise both are 0.
- R2: With select 0 and a correction taken, 6 is added to the full 16-bit accumulator, and a carry out of bit 7 increments bits 15:8.
- R3: With select 0 and a correction taken, bits 15:8 are also incremented by 1 explicitly. An input of 0x00FF with half-carry 0 gives 0x0205.
- R4: With select 1 and a correction taken, 6 is subtracted from the full 16-bit accumulator. A borrow out of bit 7 decrements bits 15:8, and bits 15:8 are then decremented by 1 explicitly. An input of 0x0000 with half-carry 1 gives 0xFE0A.
- R5: Arithmetic wraps modulo 2^16, and the high byte wraps modulo 256. Nothing propagates beyond bit 15. With select 0, 0xFFFF gives 0x0105.
- R6: Bits 7:4 of the output accumulator are always 0. Bits 3:0 hold the corrected low nibble when a correction is taken, and the input nibble otherwise.
- R7: When no correction is taken, bits 15:8 of the output equal bits 15:8 of the input.
- R8: The outputs are registered. The result for inputs present at a rising clock edge is visible after that edge. While the active-low reset is asserted, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_sub | input | 1 | 0: fix-up after addition, 1: fix-up after subtraction |
| ax_in | input | 16 | Accumulator value to adjust |
| af_in | input | 1 | Half-carry flag from the prior arithmetic |
| ax_out | output | 16 | Adjusted accumulator |
| af_out | output | 1 | New half-carry flag |
| cf_out | output | 1 | New carry flag |

## Verification
The bench targets inputs whose low byte overflows or underflows under the correction, such as 0x00FF, 0x0000 and 0x0003. A design that corrected only the low byte would give 0x0105 instead of 0x0205 at these points, or 0xFF0A instead of 0xFE0A. Wrap cases such as 0xFFFF and 0xFF09 show whether a carry leaks past bit 15 or whether the high byte fails to wrap. Nibble values 9 and 10, taken with and without the half-carry input, expose an off-by-one error in the threshold. Cases with no correction show a high byte that was altered by mistake, or upper low-byte bits that were not cleared.

// File: rtl/ascii_adj_pkg.sv
package ascii_adj_pkg;
    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } adj_op_e;

    localparam int unsigned NIB_W = 4;
endpackage

// File: rtl/ascii_adj_detect.sv
module ascii_adj_detect #(
    parameter int unsigned NIB_W = 4,
    parameter int unsigned LIMIT = 9
) (
    input  logic [NIB_W-1:0] low_nib,
    input  logic             aux_in,
    output logic             take
);
    always_comb begin
        take = aux_in | (low_nib > NIB_W'(LIMIT));
    end
endmodule

// File: rtl/ascii_adj_step.sv
// Word-wide correction folded with the explicit high-byte step into one
// constant: +/-(STEP + 2^BYTE_W). A single adder covers both effects.
module ascii_adj_step #(
    parameter int unsigned AX_W   = 16,
    parameter int unsigned BYTE_W = AX_W / 2,
    parameter int unsigned STEP   = 6
) (
    input  logic [AX_W-1:0] ax,
    input  logic            sub,
    output logic [AX_W-1:0] stepped
);
    localparam logic [AX_W-1:0] HI_ONE = AX_W'(1) << BYTE_W;
    localparam logic [AX_W-1:0] DELTA  = HI_ONE + AX_W'(STEP);

    always_comb begin
        if (sub) begin
            stepped = ax - DELTA;
        end else begin
            stepped = ax + DELTA;
        end
    end
endmodule

// File: rtl/ascii_adj_unit.sv
module ascii_adj_unit #(
    parameter int unsigned AX_W  = 16,
    parameter int unsigned LIMIT = 9,
    parameter int unsigned STEP  = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            op_sub,
    input  logic [AX_W-1:0] ax_in,
    input  logic            af_in,
    output logic [AX_W-1:0] ax_out,
    output logic            af_out,
    output logic            cf_out
);
    import ascii_adj_pkg::*;

    localparam int unsigned BYTE_W = AX_W / 2;
    localparam int unsigned HI_W   = AX_W - BYTE_W;
    localparam int unsigned PAD_W  = BYTE_W - NIB_W;

    typedef struct packed {
        logic [AX_W-1:0] ax;
        logic            af;
        logic            cf;
    } adj_res_t;

    adj_res_t        res_d, res_q;
    adj_op_e         op;
    logic            take;
    logic [AX_W-1:0] stepped;

    assign op = adj_op_e'(op_sub);

    ascii_adj_detect #(
        .NIB_W (NIB_W),
        .LIMIT (LIMIT)
    ) u_detect (
        .low_nib (ax_in[NIB_W-1:0]),
        .aux_in  (af_in),
        .take    (take)
    );

    ascii_adj_step #(
        .AX_W   (AX_W),
        .BYTE_W (BYTE_W),
        .STEP   (STEP)
    ) u_step (
        .ax      (ax_in),
        .sub     (op == OP_SUB),
        .stepped (stepped)
    );

    always_comb begin
        logic [HI_W-1:0]  hi_d;
        logic [NIB_W-1:0] lo_d;
        if (take) begin
            hi_d = stepped[AX_W-1:BYTE_W];
            lo_d = stepped[NIB_W-1:0];
        end else begin
            hi_d = ax_in[AX_W-1:BYTE_W];
            lo_d = ax_in[NIB_W-1:0];
        end
        res_d.ax = {hi_d, {PAD_W{1'b0}}, lo_d};
        res_d.af = take;
        res_d.cf = take;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign ax_out = res_q.ax;
    assign af_out = res_q.af;
    assign cf_out = res_q.cf;
endmodule

// File: rtl/ascii_adj_chk.sv
module ascii_adj_chk #(
    parameter int unsigned AX_W = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            op_sub,
    input logic [AX_W-1:0] ax_in,
    input logic            af_in,
    input logic [AX_W-1:0] ax_out,
    input logic            af_out,
    input logic            cf_out
);
    localparam int unsigned BYTE_W = AX_W / 2;

    logic seen_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
        end else begin
            seen_q <= 1'b1;
        end
    end

    AST_FLAGS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |-> (af_out == cf_out)); // R1

    AST_FLAG_RULE: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |=> (af_out == ($past(af_in) || ($past(ax_in[3:0]) > 4'd9)))); // R1

    AST_LOW_NIB_ADD: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && !op_sub && (af_in || ax_in[3:0] > 4'd9))
        |=> (ax_out[3:0] == 4'($past(ax_in[3:0]) + 4'd6))); // R2

    AST_AH_ADD_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && !op_sub && (af_in || ax_in[3:0] > 4'd9))
        |=> (8'(ax_out[AX_W-1:BYTE_W] - $past(ax_in[AX_W-1:BYTE_W])) inside {8'd1, 8'd2})); // R3

    AST_AH_SUB_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && op_sub && (af_in || ax_in[3:0] > 4'd9))
        |=> (8'($past(ax_in[AX_W-1:BYTE_W]) - ax_out[AX_W-1:BYTE_W]) inside {8'd1, 8'd2})); // R4

    AST_AL_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |-> (ax_out[7:4] == 4'd0)); // R6

    AST_NOCORR_AH_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && !af_in && ax_in[3:0] <= 4'd9)
        |=> (ax_out[AX_W-1:BYTE_W] == $past(ax_in[AX_W-1:BYTE_W]))); // R7
endmodule

bind ascii_adj_unit ascii_adj_chk #(.AX_W(AX_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .op_sub (op_sub),
    .ax_in  (ax_in),
    .af_in  (af_in),
    .ax_out (ax_out),
    .af_out (af_out),
    .cf_out (cf_out)
);

// File: tb/ascii_adj_unit_bench.sv
module ascii_adj_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_sub = 1'b0;
    logic [15:0] ax_in = '0;
    logic        af_in = 1'b0;
    logic [15:0] ax_out;
    logic        af_out, cf_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk; // 125 MHz

    ascii_adj_unit u_ascii_adj_unit (
        .clk(clk), .rst_n(rst_n), .op_sub(op_sub), .ax_in(ax_in),
        .af_in(af_in), .ax_out(ax_out), .af_out(af_out), .cf_out(cf_out)
    );

    // {op, af, ax_in, expected ax, expected flag}
    localparam int NV = 15;
    localparam logic [34:0] VEC [NV] = '{
        {1'b0, 1'b0, 16'h00FF, 16'h0205, 1'b1}, // R3 carry plus explicit step
        {1'b0, 1'b0, 16'hFFFF, 16'h0105, 1'b1}, // R5 no carry beyond bit 15
        {1'b0, 1'b1, 16'hFF09, 16'h000F, 1'b1}, // R5 high byte wraps
        {1'b0, 1'b0, 16'h0109, 16'h0109, 1'b0}, // R1 nibble 9 no correction
        {1'b0, 1'b0, 16'h010A, 16'h0200, 1'b1}, // R2 nibble 10 corrected
        {1'b0, 1'b0, 16'h00F9, 16'h0009, 1'b0}, // R6 upper nibble cleared
        {1'b0, 1'b1, 16'h1234, 16'h130A, 1'b1}, // R1 forced by half-carry
        {1'b0, 1'b0, 16'h7F0C, 16'h8002, 1'b1}, // R2 plain correction
        {1'b1, 1'b1, 16'h0000, 16'hFE0A, 1'b1}, // R4 borrow plus explicit step
        {1'b1, 1'b1, 16'h0205, 16'h000F, 1'b1}, // R4 borrow into high byte
        {1'b1, 1'b0, 16'h020F, 16'h0109, 1'b1}, // R4 no borrow
        {1'b1, 1'b0, 16'h3775, 16'h3705, 1'b0}, // R7 high byte kept
        {1'b1, 1'b1, 16'h0003, 16'hFE0D, 1'b1}, // R4 borrow wraps
        {1'b1, 1'b0, 16'h5A0B, 16'h5905, 1'b1}, // R1 nibble 11
        {1'b1, 1'b1, 16'h0106, 16'h0000, 1'b1}  // R4 lands on zero
    };

    function automatic logic [16:0] model(input logic sub, input logic af, input logic [15:0] ax);
        logic        c;
        logic [15:0] t;
        logic [7:0]  h;
        c = af || (ax[3:0] > 4'd9);
        if (!c) return {ax[15:8], 4'h0, ax[3:0], 1'b0};
        t = sub ? ax - 16'd6 : ax + 16'd6;
        h = sub ? t[15:8] - 8'd1 : t[15:8] + 8'd1;
        return {h, 4'h0, t[3:0], 1'b1};
    endfunction

    task automatic check(input string req, input logic [15:0] eax, input logic ef);
        n_chk++;
        if (ax_out !== eax || af_out !== ef || cf_out !== ef) begin
            n_bad++;
            $display("FAIL %s: got ax=%h af=%b cf=%b, expected ax=%h flags=%b",
                     req, ax_out, af_out, cf_out, eax, ef);
        end
    endtask

    task automatic apply(input logic s, input logic f, input logic [15:0] a);
        @(negedge clk);
        op_sub = s; af_in = f; ax_in = a;
        @(negedge clk);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        ax_in = 16'h00FF; af_in = 1'b1;
        repeat (3) @(negedge clk);
        check("R8 reset", 16'h0000, 1'b0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][34], VEC[i][33], VEC[i][32:17]);
            check($sformatf("R1-table vector %0d", i), VEC[i][16:1], VEC[i][0]);
        end

        // R8: one-cycle latency, result updates right after the edge
        @(negedge clk);
        op_sub = 1'b0; af_in = 1'b0; ax_in = 16'h0000;
        @(negedge clk);
        check("R8 settle", 16'h0000, 1'b0);
        ax_in = 16'h00FF;
        @(posedge clk); #1;
        check("R8 latency", 16'h0205, 1'b1);

        // R8: reset mid-run clears outputs
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R8 async reset", 16'h0000, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        // R3 and R4 against the model across random inputs
        for (int k = 0; k < 400; k++) begin
            logic [16:0] e;
            logic        s, f;
            logic [15:0] a;
            s = 1'($urandom);
            f = 1'($urandom);
            a = 16'($urandom);
            e = model(s, f, a);
            apply(s, f, a);
            check(s ? "R4 random" : "R3 random", e[16:1], e[0]);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule